// File: doc/BRIEF.md
# Half-Duplex Transmit Collision Controller

This controller sits beside the serializer of an Ethernet MAC transmitter and decides the fate of each frame when a collision or a transmit FIFO starvation occurs. It starts a transmission when a frame is waiting, measures how far into the frame the wire has advanced in bit times, and on a collision it either orders a jam followed by a randomized wait and a fresh attempt, or, if the slot window has already closed, cuts the frame short with a corrupted CRC. A starved FIFO also ends the frame with a corrupted CRC. When the frame is finished in any way, the controller tells the datapath to release it so the next one can be fetched, and it raises a one-cycle event describing the outcome.

The random wait follows truncated binary exponential backoff. For attempt number n, a whole number of slot times r is drawn from a free-running LFSR and lies in 0 to 2^min(n,10) - 1. When the port runs in full-duplex mode, the collision input has no effect, so neither retry nor late-collision handling can occur. Serialization and CRC generation stay in the datapath, which reports completion and underrun and obeys the command outputs.

Top module: `hdx_tx_collision_ctrl`

## Requirements
- R1: During and right after reset, tx_en, jam_en, bad_crc, frame_pop, all four event outputs and attempts are zero.
- R2: With the controller idle, a sampled frame_req makes tx_en high on the next cycle, and attempts reads 1.
- R3: dp_done while transmitting gives one-cycle pulses on ev_sent and frame_pop on the next cycle, with bad_crc low. tx_en drops and attempts returns to 0.
- R4: A collision sampled while fewer than SLOT_BITS bit ticks have elapsed since tx_en rose ends tx_en and holds jam_en high for exactly JAM_BITS bit ticks.
- R5: After the jam of attempt n (n below MAX_ATTEMPTS), both tx_en and jam_en stay low for r*SLOT_BITS+1 cycles with r between 0 and 2^min(n,10)-1, assuming bit_tick is held high. tx_en then rises again with attempts equal to n+1.
- R6: A collision sampled once SLOT_BITS or more bit ticks have elapsed produces one-cycle pulses on ev_late_col, bad_crc and frame_pop, with no jam and no further attempt.
- R7: When the jam following the 16th consecutive collided attempt ends, ev_retry_lim and frame_pop pulse with bad_crc low, attempts returns to 0, and tx_en stays low.
- R8: dp_underrun while transmitting gives one-cycle pulses on ev_underrun, bad_crc and frame_pop. It takes precedence over a collision sampled in the same cycle, so no jam follows.
- R9: With full_duplex high, col is ignored: tx_en stays high, jam_en stays low, and the frame ends normally on dp_done.
- R10: A collision inside the slot window sampled in the same cycle as dp_done is treated as a collision, so a jam follows instead of ev_sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_duplex | input | 1 | 1 = full-duplex link, collisions ignored |
| frame_req | input | 1 | A frame is waiting to be sent (sampled only when idle) |
| bit_tick | input | 1 | One pulse per bit time on the wire |
| col | input | 1 | Collision detected on the medium |
| dp_done | input | 1 | Datapath finished the current frame cleanly |
| dp_underrun | input | 1 | Transmit FIFO ran empty mid-frame |
| tx_en | output | 1 | Command: send frame data |
| jam_en | output | 1 | Command: send jam pattern |
| bad_crc | output | 1 | Pulse: truncate now and append a corrupted CRC |
| frame_pop | output | 1 | Pulse: release the current frame, fetch the next |
| ev_sent | output | 1 | Event pulse: frame transmitted |
| ev_late_col | output | 1 | Event pulse: collision beyond the slot window |
| ev_retry_lim | output | 1 | Event pulse: frame dropped after the attempt limit |
| ev_underrun | output | 1 | Event pulse: FIFO underrun |
| attempts | output | $clog2(MAX_ATTEMPTS+1) | Attempt number of the current frame, 0 when idle |

## Verification
Clean frames of random length check that the controller waits for dp_done and finishes on it. Collisions placed at random points inside the window exercise the jam-then-backoff path. Each measured backoff gap is checked against the attempt-dependent range, which would expose a wrong mask or an attempt count that is off by one. Collisions at exactly SLOT_BITS-1 and SLOT_BITS elapsed ticks check the window boundary. A run of sixteen collided attempts reaches the drop, and collisions repeated in full-duplex mode show that col has no effect there. Same-cycle pairs of underrun with collision and of done with collision confirm the order of outcome precedence.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SEND    = 2'd1,
        ST_JAM     = 2'd2,
        ST_BACKOFF = 2'd3
    } hdx_state_e;

    typedef struct packed {
        logic sent;
        logic late_col;
        logic retry_lim;
        logic underrun;
        logic bad_crc;
        logic pop;
    } hdx_events_t;

endpackage

// File: rtl/hdx_lfsr.sv
module hdx_lfsr #(
    parameter int            W    = 16,
    parameter logic [W-1:0]  TAPS = 16'hB400,
    parameter logic [W-1:0]  SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);
    logic [W-1:0] state_d, state_q;

    always_comb begin
        state_d = state_q >> 1;
        if (state_q[0]) begin
            state_d = state_d ^ TAPS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else begin
            state_q <= state_d;
        end
    end

    assign value = state_q;

    // the register must never reach the all-zero lock-up value
    a_r5_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
endmodule

// File: rtl/hdx_backoff_draw.sv
module hdx_backoff_draw #(
    parameter int ATT_W  = 5,
    parameter int RND_W  = 16,
    parameter int CAP    = 10
) (
    input  logic [ATT_W-1:0] attempt,
    input  logic [RND_W-1:0] rnd,
    output logic [CAP-1:0]   slots
);
    logic [CAP-1:0] mask;

    // bit i of the mask is open once the attempt number exceeds i,
    // which yields 2^min(attempt,CAP)-1
    for (genvar i = 0; i < CAP; i++) begin : g_mask
        assign mask[i] = (attempt > ATT_W'(i));
    end

    assign slots = rnd[CAP-1:0] & mask;
endmodule

// File: rtl/hdx_tx_collision_ctrl.sv
module hdx_tx_collision_ctrl #(
    parameter int SLOT_BITS    = 512,
    parameter int JAM_BITS     = 32,
    parameter int MAX_ATTEMPTS = 16,
    parameter int BACKOFF_CAP  = 10,
    parameter int LFSR_W       = 16,
    localparam int ATT_W       = $clog2(MAX_ATTEMPTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             full_duplex,
    input  logic             frame_req,
    input  logic             bit_tick,
    input  logic             col,
    input  logic             dp_done,
    input  logic             dp_underrun,
    output logic             tx_en,
    output logic             jam_en,
    output logic             bad_crc,
    output logic             frame_pop,
    output logic             ev_sent,
    output logic             ev_late_col,
    output logic             ev_retry_lim,
    output logic             ev_underrun,
    output logic [ATT_W-1:0] attempts
);
    import hdx_pkg::*;

    localparam int SLOT_W = $clog2(SLOT_BITS + 1);
    localparam int JAM_W  = (JAM_BITS > 1) ? $clog2(JAM_BITS) : 1;

    typedef struct packed {
        hdx_state_e         state;
        logic [SLOT_W-1:0]  bit_cnt;
        logic [JAM_W-1:0]   jam_cnt;
        logic [BACKOFF_CAP-1:0] slots_left;
        logic [ATT_W-1:0]   attempts;
        hdx_events_t        ev;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;

    logic [LFSR_W-1:0]      rnd;
    logic [BACKOFF_CAP-1:0] draw_slots;

    hdx_lfsr #(.W(LFSR_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .value (rnd)
    );

    hdx_backoff_draw #(.ATT_W(ATT_W), .RND_W(LFSR_W), .CAP(BACKOFF_CAP)) u_draw (
        .attempt (cur_q.attempts),
        .rnd     (rnd),
        .slots   (draw_slots)
    );

    logic in_window;
    assign in_window = (cur_q.bit_cnt < SLOT_W'(SLOT_BITS));

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.ev = '0;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (frame_req) begin
                    nxt_d.state    = ST_SEND;
                    nxt_d.bit_cnt  = '0;
                    nxt_d.attempts = ATT_W'(1);
                end
            end
            ST_SEND: begin
                if (bit_tick && in_window) begin
                    nxt_d.bit_cnt = cur_q.bit_cnt + 1'b1;
                end
                if (dp_underrun) begin
                    nxt_d.ev.underrun = 1'b1;
                    nxt_d.ev.bad_crc  = 1'b1;
                    nxt_d.ev.pop      = 1'b1;
                    nxt_d.state       = ST_IDLE;
                    nxt_d.attempts    = '0;
                end else if (col && !full_duplex) begin
                    if (in_window) begin
                        nxt_d.state   = ST_JAM;
                        nxt_d.jam_cnt = '0;
                    end else begin
                        nxt_d.ev.late_col = 1'b1;
                        nxt_d.ev.bad_crc  = 1'b1;
                        nxt_d.ev.pop      = 1'b1;
                        nxt_d.state       = ST_IDLE;
                        nxt_d.attempts    = '0;
                    end
                end else if (dp_done) begin
                    nxt_d.ev.sent  = 1'b1;
                    nxt_d.ev.pop   = 1'b1;
                    nxt_d.state    = ST_IDLE;
                    nxt_d.attempts = '0;
                end
            end
            ST_JAM: begin
                if (bit_tick) begin
                    if (cur_q.jam_cnt == JAM_W'(JAM_BITS - 1)) begin
                        if (cur_q.attempts == ATT_W'(MAX_ATTEMPTS)) begin
                            nxt_d.ev.retry_lim = 1'b1;
                            nxt_d.ev.pop       = 1'b1;
                            nxt_d.state        = ST_IDLE;
                            nxt_d.attempts     = '0;
                        end else begin
                            nxt_d.state      = ST_BACKOFF;
                            nxt_d.slots_left = draw_slots;
                            nxt_d.bit_cnt    = '0;
                        end
                    end else begin
                        nxt_d.jam_cnt = cur_q.jam_cnt + 1'b1;
                    end
                end
            end
            ST_BACKOFF: begin
                if (cur_q.slots_left == '0) begin
                    nxt_d.state    = ST_SEND;
                    nxt_d.bit_cnt  = '0;
                    nxt_d.attempts = cur_q.attempts + 1'b1;
                end else if (bit_tick) begin
                    if (cur_q.bit_cnt == SLOT_W'(SLOT_BITS - 1)) begin
                        nxt_d.bit_cnt    = '0;
                        nxt_d.slots_left = cur_q.slots_left - 1'b1;
                    end else begin
                        nxt_d.bit_cnt = cur_q.bit_cnt + 1'b1;
                    end
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign tx_en        = (cur_q.state == ST_SEND);
    assign jam_en       = (cur_q.state == ST_JAM);
    assign bad_crc      = cur_q.ev.bad_crc;
    assign frame_pop    = cur_q.ev.pop;
    assign ev_sent      = cur_q.ev.sent;
    assign ev_late_col  = cur_q.ev.late_col;
    assign ev_retry_lim = cur_q.ev.retry_lim;
    assign ev_underrun  = cur_q.ev.underrun;
    assign attempts     = cur_q.attempts;

    // R2: a transmission begun from idle is always the first attempt
    a_r2_first_attempt: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_en) && $past(!jam_en) && $past(attempts) == '0) |-> attempts == ATT_W'(1));

    // R3: a clean finish never corrupts the CRC and leaves transmission
    a_r3_clean_finish: assert property (@(posedge clk) disable iff (!rst_n)
        ev_sent |-> (frame_pop && !bad_crc && !tx_en));

    // R4: a jam only follows a collision seen inside the slot window
    a_r4_jam_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jam_en) |-> ($past(tx_en) && $past(col)));

    // R5: the attempt number never exceeds the limit
    a_r5_attempt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        attempts <= ATT_W'(MAX_ATTEMPTS));

    // R6: a late collision truncates without a jam
    a_r6_late_truncates: assert property (@(posedge clk) disable iff (!rst_n)
        ev_late_col |-> (bad_crc && frame_pop && !jam_en && $past(col)));

    // R7: the drop at the attempt limit follows a jam and keeps the CRC intact
    a_r7_limit_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ev_retry_lim |-> (frame_pop && !bad_crc && $past(jam_en)));

    // R8: an underrun always poisons the fragment
    a_r8_underrun_poison: assert property (@(posedge clk) disable iff (!rst_n)
        ev_underrun |-> (bad_crc && frame_pop && $past(dp_underrun)));

    // R9: no jam ever starts from a full-duplex collision
    a_r9_fd_no_jam: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jam_en) |-> !$past(full_duplex));

    // R1: at most one outcome event per cycle
    a_r1_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_sent, ev_late_col, ev_retry_lim, ev_underrun}));
endmodule

// File: tb/hdx_tx_collision_ctrl_test.sv
module hdx_tx_collision_ctrl_test;
    localparam int SLOT = 8;
    localparam int JAM  = 4;
    localparam int MAXA = 16;
    localparam int CAP  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic full_duplex = 1'b0, frame_req = 1'b0, bit_tick = 1'b1;
    logic col = 1'b0, dp_done = 1'b0, dp_underrun = 1'b0;
    logic tx_en, jam_en, bad_crc, frame_pop;
    logic ev_sent, ev_late_col, ev_retry_lim, ev_underrun;
    logic [4:0] attempts;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    hdx_tx_collision_ctrl #(.SLOT_BITS(SLOT), .JAM_BITS(JAM),
                            .MAX_ATTEMPTS(MAXA), .BACKOFF_CAP(CAP)) uut (
        .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .frame_req(frame_req),
        .bit_tick(bit_tick), .col(col), .dp_done(dp_done), .dp_underrun(dp_underrun),
        .tx_en(tx_en), .jam_en(jam_en), .bad_crc(bad_crc), .frame_pop(frame_pop),
        .ev_sent(ev_sent), .ev_late_col(ev_late_col), .ev_retry_lim(ev_retry_lim),
        .ev_underrun(ev_underrun), .attempts(attempts)
    );

    function automatic int max_slots(input int n);
        int e;
        e = (n < CAP) ? n : CAP;
        return (1 << e) - 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // inputs change only at negedges; outputs are sampled there too
    task automatic start_frame();
        frame_req = 1'b1;
        @(negedge clk);
        frame_req = 1'b0;
        check(tx_en == 1'b1, "R2 tx_en", int'(tx_en), 1);
        check(attempts == 5'd1, "R2 attempts", int'(attempts), 1);
    endtask

    task automatic pulse_after(input int m, ref logic sig);
        repeat (m) @(negedge clk);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic finish_clean(input int m);
        pulse_after(m, dp_done);
        check(ev_sent && frame_pop && !bad_crc, "R3 sent/pop",
              int'({ev_sent, frame_pop, bad_crc}), 6);
        check(!tx_en && attempts == 0, "R3 tx_en/attempts", int'(tx_en) + int'(attempts), 0);
        @(negedge clk);
        check(!ev_sent && !frame_pop, "R3 one-cycle pulse", int'({ev_sent, frame_pop}), 0);
    endtask

    // collision already driven; verify the jam and what follows it
    task automatic after_window_collision(input int n);
        int jl;
        int gap;
        jl = 0;
        check(jam_en && !tx_en, "R4 jam starts", int'({jam_en, tx_en}), 2);
        while (jam_en && jl < 100) begin
            jl++;
            @(negedge clk);
        end
        check(jl == JAM, "R4 jam length", jl, JAM);
        if (n == MAXA) begin
            check(ev_retry_lim && frame_pop && !bad_crc, "R7 drop",
                  int'({ev_retry_lim, frame_pop, bad_crc}), 6);
            check(attempts == 0, "R7 attempts", int'(attempts), 0);
            repeat (3 * SLOT) @(negedge clk);
            check(!tx_en && !jam_en, "R7 no retry", int'({tx_en, jam_en}), 0);
        end else begin
            gap = 0;
            while (!tx_en && gap < 20000) begin
                gap++;
                @(negedge clk);
            end
            check(gap >= 1 && (gap - 1) % SLOT == 0, "R5 gap whole slots", gap, 1);
            check((gap - 1) / SLOT <= max_slots(n), "R5 backoff range",
                  (gap - 1) / SLOT, max_slots(n));
            check(attempts == 5'(n + 1), "R5 next attempt", int'(attempts), n + 1);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(!tx_en && !jam_en && !bad_crc && !frame_pop && attempts == 0,
              "R1 reset state", int'({tx_en, jam_en, bad_crc, frame_pop}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ev_sent && !ev_late_col && !ev_retry_lim && !ev_underrun && !tx_en,
              "R1 after reset", int'({ev_sent, ev_late_col, ev_retry_lim, ev_underrun}), 0);

        // clean frames of random length
        for (int i = 0; i < 8; i++) begin
            start_frame();
            finish_clean($urandom_range(3 * SLOT, 0));
        end

        // random in-window collisions, one retry, then clean finish
        for (int i = 0; i < 6; i++) begin
            start_frame();
            pulse_after($urandom_range(SLOT - 1, 0), col);
            after_window_collision(1);
            finish_clean($urandom_range(2 * SLOT, 0));
        end

        // window boundary: last in-window tick
        start_frame();
        pulse_after(SLOT - 1, col);
        after_window_collision(1);
        finish_clean(1);

        // window boundary: first late tick (R6)
        start_frame();
        pulse_after(SLOT, col);
        check(ev_late_col && bad_crc && frame_pop, "R6 late pulses",
              int'({ev_late_col, bad_crc, frame_pop}), 7);
        check(!jam_en && !tx_en, "R6 no jam", int'({jam_en, tx_en}), 0);
        repeat (4 * SLOT) @(negedge clk);
        check(!tx_en && !jam_en, "R6 no retry", int'({tx_en, jam_en}), 0);

        // underrun alone, then underrun together with a collision (R8)
        start_frame();
        pulse_after($urandom_range(3 * SLOT, 0), dp_underrun);
        check(ev_underrun && bad_crc && frame_pop && !tx_en, "R8 underrun",
              int'({ev_underrun, bad_crc, frame_pop, tx_en}), 14);
        @(negedge clk);
        start_frame();
        repeat (2) @(negedge clk);
        col = 1'b1; dp_underrun = 1'b1;
        @(negedge clk);
        col = 1'b0; dp_underrun = 1'b0;
        check(ev_underrun && !jam_en && !ev_late_col, "R8 precedence",
              int'({ev_underrun, jam_en, ev_late_col}), 4);
        @(negedge clk);

        // done and in-window collision together: collision wins (R10)
        start_frame();
        repeat (3) @(negedge clk);
        col = 1'b1; dp_done = 1'b1;
        @(negedge clk);
        col = 1'b0; dp_done = 1'b0;
        check(!ev_sent && jam_en, "R10 collision wins", int'({ev_sent, jam_en}), 1);
        after_window_collision(1);
        finish_clean(2);

        // full duplex: collisions ignored (R9)
        full_duplex = 1'b1;
        start_frame();
        pulse_after(2, col);
        check(tx_en && !jam_en, "R9 in-window col ignored", int'({tx_en, jam_en}), 2);
        pulse_after(SLOT + 3, col);
        check(tx_en && !jam_en && !ev_late_col, "R9 late col ignored",
              int'({tx_en, jam_en, ev_late_col}), 4);
        finish_clean(1);
        full_duplex = 1'b0;

        // sixteen collided attempts reach the drop (R7)
        start_frame();
        for (int n = 1; n <= MAXA; n++) begin
            pulse_after($urandom_range(SLOT - 1, 0), col);
            after_window_collision(n);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule